// File: doc/BRIEF.md
# Modular Double-to-Int32 Converter

This unit turns a 64-bit IEEE-754 double-precision operand into a 32-bit signed integer. It rounds toward zero, keeps only the low 32 bits of the truncated integer value, and sign-extends that word to the integer register width. Finite values outside the 32-bit range are not clamped. They wrap modulo 2^32. Infinities and NaNs give zero. The unit also reports an invalid flag and an inexact flag with each result.

The unit sits beside a decoder. It accepts an operation only when the strobe is high and the three instruction fields carry the encoding of this conversion. It registers the result, the flags and an output strobe one clock later. A build parameter selects saturating behaviour instead. In that mode the unit performs a plain double-to-int32 conversion that clamps invalid inputs.

Top module: `f64_to_i32_wrap`

## Requirements
- R1: An operation is accepted only when `in_valid` is 1, `funct7` = 7'b1100001, `funct3` = 3'b001 and `rs2` = 5'b01000. In every other cycle `out_valid` is 0 on the next cycle, and `result`, `flag_invalid` and `flag_inexact` keep their previous values.
- R2: An accepted operation sets `out_valid` to 1 for exactly the one clock cycle that follows it. The result and flags for that operation are present in the same cycle.
- R3: When the wrap mode is selected (`WRAP_EN`=1), a finite operand gives the low 32 bits of its value truncated toward zero. A negative operand gives the two's complement of the truncated magnitude. This holds beyond the 32-bit range. It includes 2^83-scale values whose lowest significand bit falls on bit 31. Once the unbiased exponent reaches 84, the result is 0.
- R4: The 32-bit word is sign-extended from bit 31 to the full `XLEN` width (32 or 64).
- R5: When the wrap mode is selected, positive infinity, negative infinity, quiet NaN and signalling NaN (exponent field all ones) all give a result of 0 and raise the invalid flag.
- R6: Positive zero, negative zero, subnormals and any magnitude below 1.0 give a result of 0.
- R7: `flag_invalid` is 1 for NaN and for infinity. It is also 1 for a finite operand whose truncated value lies outside -2^31 to 2^31-1. In all other cases it is 0.
- R8: `flag_inexact` is 1 only when the operand is finite, `flag_invalid` is 0, and nonzero fractional bits were discarded. The two flags are never 1 together.
- R9: When `WRAP_EN`=0, an invalid operand gives 32'h7FFFFFFF if it is a NaN (of either sign) or positive. It gives 32'h80000000 if it is negative. Either value is sign-extended. Valid operands give the same result as in wrap mode.
- R10: A synchronous active-low reset clears `out_valid`, `result`, `flag_invalid` and `flag_inexact` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| funct7 | input | 7 | Instruction function-7 field |
| funct3 | input | 3 | Instruction function-3 field |
| rs2 | input | 5 | Instruction second-source field |
| operand | input | 64 | Raw double-precision operand |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | XLEN | Sign-extended integer result |
| flag_invalid | output | 1 | Invalid-operation flag |
| flag_inexact | output | 1 | Inexact flag |

## Verification
Every output is one register away from the inputs. The result, both flags and `out_valid` for an operation are therefore due on the clock edge that follows the cycle it was presented in. The bench drives each operand on a falling edge and samples all outputs on the next falling edge, which is half a cycle after the capturing rising edge. It drops the strobe at that same point. It then checks the following falling edge to confirm that `out_valid` has returned low and that the held result and flags have not moved. Reset is checked the same way: one falling edge after a rising edge that sees `rst_n` low.

// File: rtl/dcvt_pkg.sv
// Package: shared widths, decode constants and types for the double-to-int32
// modular converter. Assumes binary64 input and a 32-bit integer target.
package dcvt_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int MAN_W  = 52;
    localparam int SIG_W  = MAN_W + 1;
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int INT_W  = 32;
    localparam int ACC_W  = 64;

    localparam logic [6:0] OP_F7  = 7'b1100001;
    localparam logic [2:0] OP_F3  = 3'b001;
    localparam logic [4:0] OP_RS2 = 5'b01000;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } f64_t;

    typedef struct packed {
        logic is_nan;
        logic is_inf;
    } fclass_t;
endpackage

// File: rtl/dcvt_unpack.sv
// Module: splits a raw binary64 word into its fields and flags infinities
// and NaNs. Purely combinational; assumes no canonicalisation of NaNs.
module dcvt_unpack
    import dcvt_pkg::*;
(
    input  logic [FP_W-1:0] raw,
    output f64_t            fields,
    output fclass_t         cls
);
    // split the word and classify the special encodings
    always_comb begin
        fields     = f64_t'(raw);
        cls.is_inf = (fields.exp == '1) && (fields.man == '0);
        cls.is_nan = (fields.exp == '1) && (fields.man != '0);
    end
endmodule

// File: rtl/dcvt_trunc.sv
// Module: truncates a finite binary64 value toward zero and returns the low
// 32 bits of the signed integer, whether any fraction was lost, and whether
// the truncated value fits a signed 32-bit integer. Specials are not treated
// here; their large exponent simply yields a zero word and "does not fit".
module dcvt_trunc
    import dcvt_pkg::*;
(
    input  f64_t             fields,
    output logic [INT_W-1:0] low_word,
    output logic             frac_lost,
    output logic             fits
);
    logic [SIG_W-1:0] sig;
    logic [ACC_W-1:0] mag;
    logic [ACC_W-1:0] signed_mag;
    int               ue;

    // align the significand so that bit 0 holds the units digit
    always_comb begin
        sig       = {1'b1, fields.man};
        ue        = int'(fields.exp) - BIAS;
        mag       = '0;
        frac_lost = 1'b0;
        if (ue < 0) begin
            frac_lost = (fields.exp != '0) || (fields.man != '0);
        end else if (ue <= MAN_W) begin
            mag       = ACC_W'(sig) >> (MAN_W - ue);
            frac_lost = |(sig & ~({SIG_W{1'b1}} << (MAN_W - ue)));
        end else if (ue < MAN_W + INT_W) begin
            mag = ACC_W'(sig) << (ue - MAN_W);
        end
    end

    // apply the sign as a wide two's complement and keep the low word
    always_comb begin
        signed_mag = fields.sign ? (~mag + 1'b1) : mag;
        low_word   = signed_mag[INT_W-1:0];
    end

    // range test: |v| < 2^31, or exactly -2^31 after truncation
    always_comb begin
        fits = (ue < INT_W - 1) ||
               (fields.sign && (ue == INT_W - 1) &&
                (fields.man[MAN_W-1 -: INT_W-1] == '0));
    end
endmodule

// File: rtl/dcvt_select.sv
// Module: picks the final integer and flags. WRAP_EN chooses modular
// behaviour (specials to zero, out-of-range wraps) or saturating behaviour.
module dcvt_select
    import dcvt_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit WRAP_EN = 1'b1
) (
    input  logic             sign,
    input  fclass_t          cls,
    input  logic [INT_W-1:0] low_word,
    input  logic             frac_lost,
    input  logic             fits,
    output logic [XLEN-1:0]  int_res,
    output logic             nv,
    output logic             nx
);
    logic             special;
    logic [INT_W-1:0] sat_word;

    // flags are common to both variants
    always_comb begin
        special  = cls.is_nan || cls.is_inf;
        nv       = special || !fits;
        nx       = !nv && frac_lost;
        sat_word = (sign && !cls.is_nan) ? {1'b1, {(INT_W-1){1'b0}}}
                                         : {1'b0, {(INT_W-1){1'b1}}};
    end

    generate
        if (WRAP_EN) begin : g_wrap
            // specials become zero, finite values keep their wrapped word
            always_comb begin
                int_res = special ? '0 : XLEN'($signed(low_word));
            end
        end else begin : g_sat
            // invalid inputs clamp to the signed 32-bit limit
            always_comb begin
                int_res = nv ? XLEN'($signed(sat_word)) : XLEN'($signed(low_word));
            end
        end
    endgenerate
endmodule

// File: rtl/f64_to_i32_wrap.sv
// Module: top of the modular double-to-int32 converter. Decodes the op
// fields, converts combinationally, and registers result, flags and a
// one-cycle output strobe. Assumes XLEN is 32 or 64.
module f64_to_i32_wrap
    import dcvt_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit WRAP_EN = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [6:0]      funct7,
    input  logic [2:0]      funct3,
    input  logic [4:0]      rs2,
    input  logic [FP_W-1:0] operand,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic            flag_invalid,
    output logic            flag_inexact
);
    f64_t             fields;
    fclass_t          cls;
    logic [INT_W-1:0] low_word;
    logic             frac_lost;
    logic             fits;
    logic [XLEN-1:0]  int_res;
    logic             nv;
    logic             nx;
    logic             accept;

    dcvt_unpack u_unpack (
        .raw    (operand),
        .fields (fields),
        .cls    (cls)
    );

    dcvt_trunc u_trunc (
        .fields    (fields),
        .low_word  (low_word),
        .frac_lost (frac_lost),
        .fits      (fits)
    );

    dcvt_select #(.XLEN(XLEN), .WRAP_EN(WRAP_EN)) u_select (
        .sign      (fields.sign),
        .cls       (cls),
        .low_word  (low_word),
        .frac_lost (frac_lost),
        .fits      (fits),
        .int_res   (int_res),
        .nv        (nv),
        .nx        (nx)
    );

    // recognise this conversion among the incoming operations
    always_comb begin
        accept = in_valid && (funct7 == OP_F7) && (funct3 == OP_F3) && (rs2 == OP_RS2);
    end

    // capture result and flags on accept, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            result       <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                result       <= int_res;
                flag_invalid <= nv;
                flag_inexact <= nx;
            end
        end
    end
endmodule

// File: rtl/f64_to_i32_wrap_chk.sv
// Module: property checker bound to f64_to_i32_wrap. Observes ports only.
module f64_to_i32_wrap_chk
    import dcvt_pkg::*;
#(
    parameter int XLEN    = 64,
    parameter bit WRAP_EN = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [6:0]       funct7,
    input logic [2:0]       funct3,
    input logic [4:0]       rs2,
    input logic [EXP_W-1:0] exp_field,
    input logic             out_valid,
    input logic [XLEN-1:0]  result,
    input logic             flag_invalid,
    input logic             flag_inexact
);
    logic hit;
    logic armed;

    // decode seen from the ports
    always_comb begin
        hit = in_valid && (funct7 == OP_F7) && (funct3 == OP_F3) && (rs2 == OP_RS2);
    end

    // marks cycles whose previous sample lies after reset
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && result == '0 && !flag_invalid && !flag_inexact));

    assert_accept_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> out_valid);

    assert_idle_no_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !out_valid);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !out_valid) |-> ($stable(result) && $stable(flag_invalid) && $stable(flag_inexact)));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(flag_invalid && flag_inexact));

    assert_sign_extend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((result[XLEN-1:INT_W-1] == '0) || (result[XLEN-1:INT_W-1] == '1)));

    generate
        if (WRAP_EN) begin : g_wrap_chk
            assert_special_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (hit && exp_field == '1) |=> (result == '0 && flag_invalid && !flag_inexact));
        end
    endgenerate
endmodule

bind f64_to_i32_wrap f64_to_i32_wrap_chk #(.XLEN(XLEN), .WRAP_EN(WRAP_EN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .funct7       (funct7),
    .funct3       (funct3),
    .rs2          (rs2),
    .exp_field    (operand[62:52]),
    .out_valid    (out_valid),
    .result       (result),
    .flag_invalid (flag_invalid),
    .flag_inexact (flag_inexact)
);

// File: tb/f64_to_i32_wrap_tb_top.sv
// Bench: sweeps integer magnitudes, fractions, scalings and signs through a
// wrapping 64-bit instance and a saturating 32-bit instance side by side.
module f64_to_i32_wrap_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  funct7 = 7'b1100001;
    logic [2:0]  funct3 = 3'b001;
    logic [4:0]  rs2 = 5'b01000;
    logic [63:0] operand = '0;
    logic        w_vld, s_vld, w_nv, s_nv, w_nx, s_nx;
    logic [63:0] w_res;
    logic [31:0] s_res;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    f64_to_i32_wrap #(.XLEN(64), .WRAP_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct7(funct7), .funct3(funct3),
        .rs2(rs2), .operand(operand), .out_valid(w_vld), .result(w_res),
        .flag_invalid(w_nv), .flag_inexact(w_nx));

    f64_to_i32_wrap #(.XLEN(32), .WRAP_EN(1'b0)) dut_sat_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct7(funct7), .funct3(funct3),
        .rs2(rs2), .operand(operand), .out_valid(s_vld), .result(s_res),
        .flag_invalid(s_nv), .flag_inexact(s_nx));

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h op=%h", tag, act, exp, operand);
        end
    endtask

    // present one op on a falling edge, sample one falling edge later
    task automatic run_op(input logic [63:0] bits, input logic [6:0] f7,
                          input logic [2:0] f3, input logic [4:0] r2, input logic vld);
        @(negedge clk);
        operand = bits; funct7 = f7; funct3 = f3; rs2 = r2; in_valid = vld;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_both(input string tag, input logic [31:0] wword, input logic wnv,
                               input logic wnx, input logic [31:0] sword, input logic snv);
        check({tag, " R2 valid"}, {62'b0, w_vld, s_vld}, 64'd3);
        check({tag, " R3 R4 wrap result"}, w_res, {{32{wword[31]}}, wword});
        check({tag, " R7 R8 wrap flags"}, {62'b0, w_nv, w_nx}, {62'b0, wnv, wnx});
        check({tag, " R9 sat result"}, {32'b0, s_res}, {32'b0, sword});
        check({tag, " R9 sat flags"}, {62'b0, s_nv, s_nx}, {62'b0, snv, wnx});
    endtask

    // value = +/-(ip + fq/4) * 2^p, expected computed arithmetically
    task automatic run_value(input bit sg, input logic [63:0] ip, input int fq, input int p);
        real         r;
        logic [63:0] mag, sw;
        logic [63:0] lim;
        bit          fits;
        logic [31:0] word, sat;
        r = real'(longint'(ip)) + real'(fq) * 0.25;
        for (int k = 0; k < p; k++) r = r * 2.0;
        if (sg) r = -r;
        mag  = (p >= 64) ? 64'd0 : (ip << p);
        sw   = sg ? (~mag + 64'd1) : mag;
        word = sw[31:0];
        lim  = sg ? 64'h8000_0000 : 64'h7FFF_FFFF;
        fits = (ip == 0) || ((p <= 31) && (ip <= (lim >> p)));
        sat  = fits ? word : (sg ? 32'h8000_0000 : 32'h7FFF_FFFF);
        run_op($realtobits(r), 7'b1100001, 3'b001, 5'b01000, 1'b1);
        expect_both("value", word, !fits, fits && (fq != 0), sat, !fits);
    endtask

    initial begin
        logic [63:0] ips_a [12];
        logic [63:0] ips_b [5];
        logic [63:0] specials [6];
        ips_a = '{64'd0, 64'd1, 64'd2, 64'd3, 64'd5, 64'h7FFF_FFFF, 64'h8000_0000,
                  64'h8000_0001, 64'hFFFF_FFFF, 64'h1_0000_0000, 64'h1_2345_6789,
                  64'h3_FFFF_FFFF_FFFF};
        ips_b = '{64'd1, 64'd3, 64'h1F_FFFF_FFFF_FFFF, 64'h15_5555_5555_5555, 64'h12345};
        // +inf, -inf, +qNaN, +sNaN, -qNaN, -sNaN
        specials = '{64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
                     64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001,
                     64'hFFF8_0000_0000_0000, 64'hFFF4_0000_0000_0000};

        // R10: outputs clear under reset
        repeat (3) @(negedge clk);
        check("R10 reset wrap", {w_res, 1'b0} | {63'b0, w_vld | w_nv | w_nx}, 64'd0);
        check("R10 reset sat", {31'b0, s_res, s_vld | s_nv | s_nx}, 64'd0);
        rst_n = 1'b1;

        // R3 R6 R7 R8 R9: integer parts with quarter fractions, both signs
        for (int sg = 0; sg < 2; sg++)
            for (int i = 0; i < 12; i++)
                for (int fq = 0; fq < 4; fq++)
                    run_value(sg[0], ips_a[i], fq, 0);

        // R3: scaled values across and beyond the 32-bit range, up to 2^148
        for (int sg = 0; sg < 2; sg++)
            for (int i = 0; i < 5; i++)
                for (int p = 0; p < 96; p++)
                    run_value(sg[0], ips_b[i], 0, p);

        // R3: lowest significand bit on bit 31 gives -2^31 in the word
        run_value(1'b0, 64'h1F_FFFF_FFFF_FFFF, 0, 31);
        check("R3 R4 exponent 83 word", w_res, 64'hFFFF_FFFF_8000_0000);
        run_value(1'b0, 64'h1F_FFFF_FFFF_FFFF, 0, 32);
        check("R3 exponent 84 zero", w_res, 64'd0);

        // R5 R7 R9: infinities and NaNs
        for (int i = 0; i < 6; i++) begin
            run_op(specials[i], 7'b1100001, 3'b001, 5'b01000, 1'b1);
            expect_both("R5 special", 32'd0, 1'b1, 1'b0,
                        (i == 1) ? 32'h8000_0000 : 32'h7FFF_FFFF, 1'b1);
        end

        // R6 R8: subnormals give zero and are inexact
        run_op(64'h000F_FFFF_FFFF_FFFF, 7'b1100001, 3'b001, 5'b01000, 1'b1);
        expect_both("R6 subnormal", 32'd0, 1'b0, 1'b1, 32'd0, 1'b0);
        run_op(64'h8000_0000_0000_0001, 7'b1100001, 3'b001, 5'b01000, 1'b1);
        expect_both("R6 neg subnormal", 32'd0, 1'b0, 1'b1, 32'd0, 1'b0);

        // R1 R2: a known value, then strobe drop and ignored encodings
        run_value(1'b0, 64'd5, 0, 0);
        @(negedge clk);
        check("R2 single-cycle strobe", {62'b0, w_vld, s_vld}, 64'd0);
        run_op(64'hFFF0_0000_0000_0000, 7'b1100001, 3'b000, 5'b01000, 1'b1);
        check("R1 funct3 ignored", {w_res[62:0], w_vld}, {63'd5, 1'b0});
        run_op(64'hFFF0_0000_0000_0000, 7'b1100000, 3'b001, 5'b01000, 1'b1);
        check("R1 funct7 ignored", {w_res[62:0], w_vld}, {63'd5, 1'b0});
        run_op(64'hFFF0_0000_0000_0000, 7'b1100001, 3'b001, 5'b01001, 1'b1);
        check("R1 rs2 ignored", {w_res[62:0], w_vld}, {63'd5, 1'b0});
        run_op(64'hFFF0_0000_0000_0000, 7'b1100001, 3'b001, 5'b01000, 1'b0);
        check("R1 strobe low ignored", {w_res[62:0], w_vld}, {63'd5, 1'b0});
        check("R1 flags held", {62'b0, w_nv, w_nx, 32'b0} | {32'b0, s_res}, 64'd5);

        // R10: synchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset again", w_res | {63'b0, w_vld | w_nv | w_nx}, 64'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule